// File: doc/BRIEF.md
# Interrupt Aggregator with Shared Output Pin

This block gathers event indications from three groups of sources (transmit, receive and system) and folds them into a single interrupt pin. Every source owns one status bit and one enable bit. Status bits record what happened whether or not the source is enabled, so software can poll them and leave the pin unused. The pin asserts while any source has both its status and its enable set.

Most sources are pulse events. Their status bits latch and clear when software reads their status register. The top bit of the system group is different: it carries a low-battery comparator level. That bit follows the live level, is never latched, and a read does not clear it. A configuration register selects the pin's active level and whether the pin drives push-pull or open drain. Open drain is modelled as an output value together with an output-enable.

Software reaches the registers through a plain register port. A read returns its data one clock after the request.

Top module: `irq_aggregator`

## Requirements
- R1: A pulse on a latched source sets its status bit at the next clock edge. The bit stays set until its status register is read, and this holds whether the source's enable is 0 or 1.
- R2: A read of a group's status register returns the value held before the edge and clears that group's latched bits at the same edge. A source pulsing in the cycle of the read stays set afterwards.
- R3: System status bit SRC_W-1 equals the `batt_low` input at all times. Reads never clear it, and it contributes to the pin while `batt_low` is high.
- R4: An enable register changes only on a write to its own address. Events, reads and writes to other addresses leave it unchanged.
- R5: The pin is asserted exactly when the OR over all sources of (status AND enable) is true. The active level is applied after the OR.
- R6: When configuration bit 0 is 1, an asserted pin gives `irq_out`=1. When it is 0, an asserted pin gives `irq_out`=0, and the deasserted level is always the opposite value.
- R7: When configuration bit 1 is 0 (push-pull), `irq_oe` is always 1. When it is 1 (open drain), `irq_oe` is 1 only while the pin is asserted.
- R8: After reset, all enables, status bits and the configuration are 0. With `batt_low` low, this gives `irq_out`=1, `irq_oe`=1 and `rd_data`=0.
- R9: The register map is as follows. Address 0 is the transmit enable, 1 the receive enable and 2 the system enable. Address 4 is transmit status, 5 receive status and 6 system status. Address 7 is the configuration, with bit 0 selecting the active-high level and bit 1 selecting open drain. Reads of address 3 return 0. Writes to 3 through 6 have no effect.
- R10: `rd_data` updates at the clock edge where `rd_en` is sampled high and holds its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_evt | input | SRC_W | Transmit event pulses |
| rx_evt | input | SRC_W | Receive event pulses |
| sys_evt | input | SRC_W-1 | System event pulses |
| batt_low | input | 1 | Live low-battery comparator level |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wr_data | input | SRC_W | Write data |
| rd_data | output | SRC_W | Read data, valid the cycle after `rd_en` |
| irq_out | output | 1 | Pin value after the active-level selection |
| irq_oe | output | 1 | Pin output enable |

## Verification
A lost or stuck latched status bit appears in the next read of its group. If the source is enabled, it also appears on the pin at the following sample, because the pin is combinational from the status and enable registers. A corrupted enable or configuration bit shows up on `irq_out` or `irq_oe` within a cycle of any enabled event, and in the next read of that register. A wrong clear priority shows up only when a read and a pulse coincide, so the stimulus forces that overlap both deliberately and at random.

// File: rtl/irq_agg_pkg.sv
// Package: shared constants and the register address map of the interrupt aggregator.
// Assumes a 3-bit address and three source groups.
package irq_agg_pkg;
    localparam int NGRP   = 3;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_EN_TX  = 3'd0,
        A_EN_RX  = 3'd1,
        A_EN_SYS = 3'd2,
        A_SPARE  = 3'd3,
        A_ST_TX  = 3'd4,
        A_ST_RX  = 3'd5,
        A_ST_SYS = 3'd6,
        A_CFG    = 3'd7
    } reg_addr_e;

    localparam logic [ADDR_W-1:0] ST_BASE = A_ST_TX;
    localparam int CFG_POL_BIT = 0;
    localparam int CFG_OD_BIT  = 1;
endpackage

// File: rtl/irq_group.sv
// Module: one interrupt group, holding an enable register and per-source status.
// Bits set in LIVE_MASK follow src_in as a level. All other bits latch a pulse
// on src_in and are cleared by st_rd. An event arriving in the same cycle as
// st_rd wins over the clear. Assumes synchronous active-low reset.
module irq_group #(
    parameter int SRC_W = 4,
    parameter logic [SRC_W-1:0] LIVE_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_in,
    input  logic             en_wr,
    input  logic [SRC_W-1:0] wr_data,
    input  logic             st_rd,
    output logic [SRC_W-1:0] en_q,
    output logic [SRC_W-1:0] status
);
    // Enable register: loads only on a write to this group's enable address.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= wr_data;
    end

    for (genvar b = 0; b < SRC_W; b++) begin : g_bit
        if (LIVE_MASK[b]) begin : g_live
            // Level source: status mirrors the input directly.
            assign status[b] = src_in[b];
        end else begin : g_latch
            logic flag_q;
            // Latched source: set on a pulse, clear on read, a new pulse beats the clear.
            always_ff @(posedge clk) begin
                if (!rst_n)         flag_q <= 1'b0;
                else if (st_rd)     flag_q <= src_in[b];
                else if (src_in[b]) flag_q <= 1'b1;
            end
            assign status[b] = flag_q;
        end
    end
endmodule

// File: rtl/irq_pin_drive.sv
// Module: applies the active level and the drive mode to the combined interrupt.
// Push-pull always enables the pad. Open drain enables it only while asserted.
module irq_pin_drive (
    input  logic active,
    input  logic pol_high,
    input  logic open_drain,
    output logic pin_o,
    output logic pin_oe
);
    // Active level applied after the OR; the output enable depends on the drive mode.
    always_comb begin
        pin_o  = pol_high ? active : ~active;
        pin_oe = open_drain ? active : 1'b1;
    end
endmodule

// File: rtl/irq_aggregator.sv
// Module: top of the interrupt aggregator. It decodes the register port, instantiates
// three source groups (the top system bit is the live low-battery level), ORs
// status AND enable into one pin, and registers read data one cycle after rd_en.
// Assumes a synchronous active-low reset and SRC_W >= 2.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int SRC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  tx_evt,
    input  logic [SRC_W-1:0]  rx_evt,
    input  logic [SRC_W-2:0]  sys_evt,
    input  logic              batt_low,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SRC_W-1:0]  wr_data,
    output logic [SRC_W-1:0]  rd_data,
    output logic              irq_out,
    output logic              irq_oe
);
    localparam logic [SRC_W-1:0] SYS_LIVE = SRC_W'(1) << (SRC_W - 1);

    logic [NGRP-1:0][SRC_W-1:0] src_arr;
    logic [NGRP-1:0][SRC_W-1:0] en_arr;
    logic [NGRP-1:0][SRC_W-1:0] st_arr;
    logic [1:0]                 cfg_q;
    logic                       any_act;

    assign src_arr[0] = tx_evt;
    assign src_arr[1] = rx_evt;
    assign src_arr[2] = {batt_low, sys_evt};

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic en_wr_g;
        logic st_rd_g;
        assign en_wr_g = wr_en && (addr == ADDR_W'(g));
        assign st_rd_g = rd_en && (addr == ST_BASE + ADDR_W'(g));
        irq_group #(
            .SRC_W    (SRC_W),
            .LIVE_MASK((g == NGRP - 1) ? SYS_LIVE : '0)
        ) u_grp (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_in (src_arr[g]),
            .en_wr  (en_wr_g),
            .wr_data(wr_data),
            .st_rd  (st_rd_g),
            .en_q   (en_arr[g]),
            .status (st_arr[g])
        );
    end

    // Configuration register: active level and drive mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cfg_q <= 2'b00;
        else if (wr_en && addr == A_CFG) cfg_q <= wr_data[1:0];
    end

    // Combine all enabled status bits into a single active flag.
    assign any_act = |(st_arr & en_arr);

    irq_pin_drive u_pin (
        .active    (any_act),
        .pol_high  (cfg_q[CFG_POL_BIT]),
        .open_drain(cfg_q[CFG_OD_BIT]),
        .pin_o     (irq_out),
        .pin_oe    (irq_oe)
    );

    // Registered read mux: captures the addressed register when rd_en is high.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else if (rd_en) begin
            case (addr)
                A_EN_TX:  rd_data <= en_arr[0];
                A_EN_RX:  rd_data <= en_arr[1];
                A_EN_SYS: rd_data <= en_arr[2];
                A_ST_TX:  rd_data <= st_arr[0];
                A_ST_RX:  rd_data <= st_arr[1];
                A_ST_SYS: rd_data <= st_arr[2];
                A_CFG:    rd_data <= SRC_W'(cfg_q);
                default:  rd_data <= '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_aggregator_chk.sv
// Module: assertion checker bound into irq_aggregator. It observes ports and
// internal registers and never drives anything.
module irq_aggregator_chk
    import irq_agg_pkg::*;
#(
    parameter int SRC_W = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic                       rd_en,
    input logic [ADDR_W-1:0]          addr,
    input logic [SRC_W-1:0]           tx_evt,
    input logic                       batt_low,
    input logic [SRC_W-1:0]           rd_data,
    input logic                       irq_out,
    input logic                       irq_oe,
    input logic [NGRP-1:0][SRC_W-1:0] en_arr,
    input logic [NGRP-1:0][SRC_W-1:0] st_arr,
    input logic [1:0]                 cfg_q
);
    logic act_c;
    assign act_c = |(st_arr & en_arr);

    AST_STICKY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && addr == A_ST_TX) |=> ((st_arr[0] & $past(st_arr[0])) == $past(st_arr[0]))); // R1
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_ST_TX) |=> (st_arr[0] == $past(tx_evt))); // R2
    AST_LEVEL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_ST_SYS) |=> (rd_data[SRC_W-1] == $past(batt_low))); // R3
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_EN_TX) |=> $stable(en_arr[0])); // R4
    AST_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        act_c |-> (irq_out == cfg_q[CFG_POL_BIT])); // R6
    AST_OD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[CFG_OD_BIT] && !act_c) |-> !irq_oe); // R7
    AST_PP_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[CFG_OD_BIT] |-> irq_oe); // R7
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R10
endmodule

bind irq_aggregator irq_aggregator_chk #(.SRC_W(SRC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .tx_evt  (tx_evt),
    .batt_low(batt_low),
    .rd_data (rd_data),
    .irq_out (irq_out),
    .irq_oe  (irq_oe),
    .en_arr  (en_arr),
    .st_arr  (st_arr),
    .cfg_q   (cfg_q)
);

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
    localparam int W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] tx_evt = '0, rx_evt = '0, wr_data = '0;
    logic [W-2:0] sys_evt = '0;
    logic batt_low = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [W-1:0] rd_data;
    logic irq_out, irq_oe;

    int checks = 0, errors = 0;
    logic [W-1:0] m_en [3];
    logic [W-1:0] m_st [3];
    logic [1:0]   m_cfg;
    logic [W-1:0] m_rd;

    always #2 clk = ~clk;

    irq_aggregator #(.SRC_W(W)) u_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .tx_evt(tx_evt), .rx_evt(rx_evt),
        .sys_evt(sys_evt), .batt_low(batt_low), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .irq_out(irq_out), .irq_oe(irq_oe)
    );

    function automatic logic [W-1:0] sys_view();
        return {batt_low, m_st[2][W-2:0]};
    endfunction

    function automatic logic [W-1:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0, 3'd1, 3'd2: return m_en[a];
            3'd4: return m_st[0];
            3'd5: return m_st[1];
            3'd6: return sys_view();
            3'd7: return W'(m_cfg);
            default: return '0;
        endcase
    endfunction

    function automatic logic exp_act();
        return |(m_st[0] & m_en[0]) | |(m_st[1] & m_en[1]) | |(sys_view() & m_en[2]);
    endfunction

    task automatic check(input logic ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive at the current negedge, update the model at posedge, check at the next negedge.
    task automatic cyc(input logic [W-1:0] tx, input logic [W-1:0] rx, input logic [W-2:0] sy,
                       input logic bl, input logic we, input logic re, input logic [2:0] a,
                       input logic [W-1:0] d, input string tag);
        logic [W-1:0] rexp;
        logic act;
        tx_evt = tx; rx_evt = rx; sys_evt = sy; batt_low = bl;
        wr_en = we; rd_en = re; addr = a; wr_data = d;
        #1;
        rexp = exp_read(a);
        @(posedge clk);
        if (re) m_rd = rexp;
        m_st[0] = (re && a == 3'd4) ? tx : (m_st[0] | tx);
        m_st[1] = (re && a == 3'd5) ? rx : (m_st[1] | rx);
        m_st[2] = (re && a == 3'd6) ? W'(sy) : (m_st[2] | W'(sy));
        if (we && a < 3'd3) m_en[a] = d;
        if (we && a == 3'd7) m_cfg = d[1:0];
        @(negedge clk);
        act = exp_act();
        check(rd_data == m_rd, re ? tag : "R10", rd_data, m_rd);
        check(irq_out == (m_cfg[0] ? act : ~act), "R5/R6", W'(irq_out), W'(m_cfg[0] ? act : ~act));
        check(irq_oe == (m_cfg[1] ? act : 1'b1), "R7", W'(irq_oe), W'(m_cfg[1] ? act : 1'b1));
    endtask

    task automatic idle(input string tag);
        cyc('0, '0, '0, batt_low, 1'b0, 1'b0, 3'd0, '0, tag);
    endtask

    initial begin
        int unsigned seed;
        for (int g = 0; g < 3; g++) begin m_en[g] = '0; m_st[g] = '0; end
        m_cfg = '0; m_rd = '0;
        seed = $urandom(32'd1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset values
        check(irq_out == 1'b1, "R8", W'(irq_out), W'(1));
        check(irq_oe == 1'b1, "R8", W'(irq_oe), W'(1));
        check(rd_data == '0, "R8", rd_data, '0);
        rst_n = 1'b1;
        // R9 / R4: enable write and readback
        cyc('0, '0, '0, 1'b0, 1'b1, 1'b0, 3'd0, 4'b0010, "R9");
        cyc('0, '0, '0, 1'b0, 1'b0, 1'b1, 3'd0, '0, "R4");
        // R5: enabled tx event asserts the pin (active low)
        cyc(4'b0010, '0, '0, 1'b0, 1'b0, 1'b0, 3'd0, '0, "R5");
        check(irq_out == 1'b0, "R5", W'(irq_out), W'(0));
        // R2: read returns and clears
        cyc('0, '0, '0, 1'b0, 1'b0, 1'b1, 3'd4, '0, "R2");
        check(irq_out == 1'b1, "R2", W'(irq_out), W'(1));
        // R1: disabled rx source still latches status
        cyc('0, 4'b0001, '0, 1'b0, 1'b0, 1'b0, 3'd0, '0, "R1");
        idle("R1");
        // R2: same-cycle event and read, new event survives
        cyc('0, 4'b0100, '0, 1'b0, 1'b0, 1'b1, 3'd5, '0, "R1");
        cyc('0, '0, '0, 1'b0, 1'b0, 1'b1, 3'd5, '0, "R2");
        // R3: live battery bit, enabled, read twice without clearing
        cyc('0, '0, '0, 1'b1, 1'b1, 1'b0, 3'd2, 4'b1000, "R3");
        cyc('0, '0, '0, 1'b1, 1'b0, 1'b1, 3'd6, '0, "R3");
        cyc('0, '0, '0, 1'b1, 1'b0, 1'b1, 3'd6, '0, "R3");
        cyc('0, '0, '0, 1'b0, 1'b0, 1'b0, 3'd0, '0, "R3");
        // R9: writes to status and spare addresses ignored; spare reads zero
        cyc('0, '0, '0, 1'b0, 1'b1, 1'b0, 3'd4, 4'b1111, "R9");
        cyc('0, '0, '0, 1'b0, 1'b1, 1'b1, 3'd3, 4'b1111, "R9");
        cyc('0, '0, '0, 1'b0, 1'b0, 1'b1, 3'd4, '0, "R9");
        // R6 / R7: open drain, active high
        cyc('0, '0, '0, 1'b0, 1'b1, 1'b0, 3'd7, 4'b0011, "R7");
        cyc('0, '0, '0, 1'b1, 1'b0, 1'b0, 3'd0, '0, "R6");
        check(irq_out == 1'b1 && irq_oe == 1'b1, "R6", {2'b0, irq_out, irq_oe}, 4'b0011);
        cyc('0, '0, '0, 1'b0, 1'b0, 1'b0, 3'd0, '0, "R7");
        check(irq_oe == 1'b0, "R7", W'(irq_oe), W'(0));
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] tx, rx;
            logic [W-2:0] sy;
            tx = (($urandom % 4) == 0) ? W'($urandom) : '0;
            rx = (($urandom % 4) == 0) ? W'($urandom) : '0;
            sy = (($urandom % 4) == 0) ? (W-1)'($urandom) : '0;
            cyc(tx, rx, sy, (($urandom % 8) == 0) ? ~batt_low : batt_low,
                ($urandom % 3) == 0, ($urandom % 3) == 0, 3'($urandom), W'($urandom), "R9");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule